// File: doc/BRIEF.md
# Byte-Coherent 16-bit Timer Channel

This block is a 16-bit up-counter driven through a power-of-two prescaler and paired with one capture/compare channel. Software reaches it over an 8-bit register port, so every 16-bit quantity is split into a high and a low byte register. Two mechanisms keep such split accesses consistent. First, a read of a high byte freezes a copy of the matching low byte. Second, a two-byte compare-value write is collected in a buffer and takes effect as a whole.

A debug-halt input stops the counter so a debugger can inspect the block. While halted, reads show live register contents, and certain writes drop any pending low-byte copy. The channel either captures the count on a rising input edge or compares the count against a programmed value, toggling an output on a match.

Register addresses on `bus_addr`: 0 timer control, 1 counter high, 2 counter low, 3 channel control, 4 channel value high, 5 channel value low. Other addresses read as zero.

Top module: `bct_timer`

## Requirements
- R1: While `clk_sel` is nonzero and `dbg_halt` is low, the counter advances once every 2^`psc_sel` clock cycles. After a clear followed by M running cycles it holds M >> `psc_sel`. Any nonzero `clk_sel` value selects the bus clock.
- R2: The counter steps from 0xFFFF to 0x0000 and then continues counting.
- R3: With `clk_sel` = 00, both the counter and the prescaler phase hold their values. Register 0 reads back `clk_sel` in bits [4:3] and `psc_sel` in bits [2:0], with all other bits zero.
- R4: A write of any data to register 1 or 2 sets the counter to zero and restarts the prescaler phase.
- R5: Outside debug-halt, a read of register 1 (or 4) saves the current low byte of the counter (or channel value). The next read of register 2 (or 5) returns the saved byte and releases it. A low-byte read with nothing saved returns the live byte.
- R6: While `dbg_halt` is high, the counter does not change. Reads of registers 1, 2, 4 and 5 return live contents, and these reads neither save nor release a low-byte copy.
- R7: While `dbg_halt` is high, a write to register 0, 1 or 2 discards the counter's saved low byte. A write to register 3 discards the channel's saved low byte.
- R8: Channel control bit 0 selects the mode (1 = capture, 0 = compare). In capture mode, writes to registers 4 and 5 leave the channel value unchanged.
- R9: In compare mode with `clk_sel` nonzero, channel-value byte writes are held in a buffer. Once both bytes have been written, the buffer moves to the channel value at the first counter step after the cycle that completed the pair.
- R10: In compare mode with `clk_sel` = 00, the channel value takes the buffered pair in the same cycle as the write that completes the pair. A lone byte write changes nothing.
- R11: In compare mode, when the counter steps onto the channel value, channel control bit 7 (the flag) becomes 1 and `cmp_out` inverts.
- R12: In capture mode, a rising edge of `cap_in` copies the counter into the channel value and sets the flag. A level held high does not capture again.
- R13: Writing channel control with bit 7 = 1 clears the flag, and writing it with bit 7 = 0 leaves the flag as it is. If a set event occurs in the same cycle as a clear, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe; side effects occur at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| clk_sel | input | 2 | Count source: 00 stopped, other values bus clock |
| psc_sel | input | 3 | Prescale exponent |
| dbg_halt | input | 1 | Debug halt |
| cap_in | input | 1 | Capture input, synchronous to `clk` |
| cmp_out | output | 1 | Compare output, inverts on every match |

## Verification
The assertions assume one bus strobe at a time on a single address. They also assume `cap_in` is synchronous to `clk` and stays low through reset, so that its first rising edge is a real edge. The stimulus drives every input at the falling clock edge, issues reads and writes one per cycle without overlap, and holds `cap_in` low until the capture test. Counting is started and stopped only by toggling `clk_sel` while the counter is otherwise idle, so every expected count follows from the number of running cycles.

// File: rtl/bct_pkg.sv
// Package: register addresses shared by the timer, its checker and its users.
// Assumes a 3-bit register address space.
package bct_pkg;
    localparam int AW = 3;
    localparam logic [AW-1:0] A_TCTL = 3'd0;
    localparam logic [AW-1:0] A_CNTH = 3'd1;
    localparam logic [AW-1:0] A_CNTL = 3'd2;
    localparam logic [AW-1:0] A_CCTL = 3'd3;
    localparam logic [AW-1:0] A_CHVH = 3'd4;
    localparam logic [AW-1:0] A_CHVL = 3'd5;
endpackage

// File: rtl/bct_prescaler.sv
// Prescaler: free-running phase counter that emits a one-cycle tick every
// 2^psc_sel cycles while run is high. Assumes psc_sel < 2^PSW.
module bct_prescaler #(
    parameter int PSW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           clear,
    input  logic [PSW-1:0] psc_sel,
    output logic           tick
);
    localparam int PCW = (1 << PSW) - 1;

    logic [PCW-1:0] phase;
    logic [PCW-1:0] mask;

    // Low psc_sel bits of the phase form the division window.
    always_comb begin
        mask = ~({PCW{1'b1}} << psc_sel);
        tick = run && ((phase & mask) == mask);
    end

    // Phase advances only while running; a clear restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n)     phase <= '0;
        else if (clear) phase <= '0;
        else if (run)   phase <= phase + 1'b1;
    end
endmodule

// File: rtl/bct_rdlatch.sv
// Read-coherency holder: saves the low byte when the high byte is read and
// hands it back on the next low-byte read. Assumes the caller already masks
// rd_hi/rd_lo during debug halt.
module bct_rdlatch #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_hi,
    input  logic          rd_lo,
    input  logic          clear,
    input  logic [DW-1:0] live_lo,
    output logic          held,
    output logic [DW-1:0] held_lo
);
    // Clear wins, then a high read captures, then a low read releases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held    <= 1'b0;
            held_lo <= '0;
        end else if (clear) begin
            held <= 1'b0;
        end else if (rd_hi) begin
            held    <= 1'b1;
            held_lo <= live_lo;
        end else if (rd_lo) begin
            held <= 1'b0;
        end
    end
endmodule

// File: rtl/bct_channel.sv
// Capture/compare channel with a two-byte write buffer. Assumes cap_in is
// synchronous to clk and that only one byte strobe is active per cycle.
module bct_channel #(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            clk_off,
    input  logic [2*DW-1:0] count,
    input  logic            wr_ctl,
    input  logic            wr_hi,
    input  logic            wr_lo,
    input  logic [DW-1:0]   wdata,
    input  logic            cap_in,
    output logic [2*DW-1:0] chv,
    output logic            flag,
    output logic            cap_mode,
    output logic            cmp_out
);
    localparam int CW = 2 * DW;

    logic [DW-1:0] buf_hi, buf_lo, nxt_hi, nxt_lo;
    logic          got_hi, got_lo, pend, cap_q;
    logic          cmp_mode, pair_done, cap_hit, cmp_hit;
    logic [CW-1:0] cnt_next;

    // Event decode: completed pair, capture edge and compare hit.
    always_comb begin
        cmp_mode  = !cap_mode;
        nxt_hi    = wr_hi ? wdata : buf_hi;
        nxt_lo    = wr_lo ? wdata : buf_lo;
        pair_done = cmp_mode && (wr_hi || wr_lo) && (got_hi || wr_hi) && (got_lo || wr_lo);
        cap_hit   = cap_mode && cap_in && !cap_q;
        cnt_next  = count + 1'b1;
        cmp_hit   = cmp_mode && tick && (cnt_next == chv);
    end

    // Edge history for the capture input.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= 1'b0;
        else        cap_q <= cap_in;
    end

    // Byte buffer contents; filled only in compare mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_hi <= '0;
            buf_lo <= '0;
        end else begin
            if (cmp_mode && wr_hi) buf_hi <= wdata;
            if (cmp_mode && wr_lo) buf_lo <= wdata;
        end
    end

    // Tracks which bytes of the current pair have arrived.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            got_hi <= 1'b0;
            got_lo <= 1'b0;
        end else if (pair_done) begin
            got_hi <= 1'b0;
            got_lo <= 1'b0;
        end else begin
            if (cmp_mode && wr_hi) got_hi <= 1'b1;
            if (cmp_mode && wr_lo) got_lo <= 1'b1;
        end
    end

    // Pending transfer waiting for the next counter step.
    always_ff @(posedge clk) begin
        if (!rst_n)                     pend <= 1'b0;
        else if (pair_done)             pend <= !clk_off;
        else if (pend && tick && cmp_mode) pend <= 1'b0;
    end

    // Channel value: capture, immediate commit or step-aligned commit.
    always_ff @(posedge clk) begin
        if (!rst_n)                          chv <= '0;
        else if (cap_hit)                    chv <= count;
        else if (pair_done && clk_off)       chv <= {nxt_hi, nxt_lo};
        else if (pend && tick && cmp_mode)   chv <= {buf_hi, buf_lo};
    end

    // Mode bit from channel control bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)      cap_mode <= 1'b0;
        else if (wr_ctl) cap_mode <= wdata[0];
    end

    // Flag: set events win over a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                        flag <= 1'b0;
        else if (cap_hit || cmp_hit)       flag <= 1'b1;
        else if (wr_ctl && wdata[DW-1])    flag <= 1'b0;
    end

    // Compare output inverts on each match.
    always_ff @(posedge clk) begin
        if (!rst_n)       cmp_out <= 1'b0;
        else if (cmp_hit) cmp_out <= !cmp_out;
    end
endmodule

// File: rtl/bct_timer.sv
// Top: 16-bit timer with prescaler, one capture/compare channel and byte-wide
// register access with read coherency. Assumes one bus strobe per cycle.
module bct_timer
    import bct_pkg::*;
#(
    parameter int DW  = 8,
    parameter int PSW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic [1:0]     clk_sel,
    input  logic [PSW-1:0] psc_sel,
    input  logic           dbg_halt,
    input  logic           cap_in,
    output logic           cmp_out
);
    localparam int CW = 2 * DW;

    logic          wr_tctl, wr_cnt, wr_cctl, wr_vh, wr_vl;
    logic          rd_cnth, rd_cntl, rd_vh, rd_vl;
    logic          clk_off, run, tick;
    logic [CW-1:0] count, chv;
    logic          flag, cap_mode;
    logic          cnt_held, ch_held;
    logic [DW-1:0] cnt_held_lo, ch_held_lo, cctl_rd;

    // Address decode; coherency reads are masked during debug halt.
    always_comb begin
        wr_tctl = bus_wr && (bus_addr == A_TCTL);
        wr_cnt  = bus_wr && ((bus_addr == A_CNTH) || (bus_addr == A_CNTL));
        wr_cctl = bus_wr && (bus_addr == A_CCTL);
        wr_vh   = bus_wr && (bus_addr == A_CHVH);
        wr_vl   = bus_wr && (bus_addr == A_CHVL);
        rd_cnth = bus_rd && !dbg_halt && (bus_addr == A_CNTH);
        rd_cntl = bus_rd && !dbg_halt && (bus_addr == A_CNTL);
        rd_vh   = bus_rd && !dbg_halt && (bus_addr == A_CHVH);
        rd_vl   = bus_rd && !dbg_halt && (bus_addr == A_CHVL);
        clk_off = (clk_sel == 2'b00);
        run     = !clk_off && !dbg_halt;
    end

    bct_prescaler #(.PSW(PSW)) i_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .clear   (wr_cnt),
        .psc_sel (psc_sel),
        .tick    (tick)
    );

    // Main counter: byte write clears, tick advances with natural wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (wr_cnt) count <= '0;
        else if (tick)   count <= count + 1'b1;
    end

    bct_rdlatch #(.DW(DW)) i_cnt_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_hi   (rd_cnth),
        .rd_lo   (rd_cntl),
        .clear   (dbg_halt && (wr_tctl || wr_cnt)),
        .live_lo (count[DW-1:0]),
        .held    (cnt_held),
        .held_lo (cnt_held_lo)
    );

    bct_rdlatch #(.DW(DW)) i_ch_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_hi   (rd_vh),
        .rd_lo   (rd_vl),
        .clear   (dbg_halt && wr_cctl),
        .live_lo (chv[DW-1:0]),
        .held    (ch_held),
        .held_lo (ch_held_lo)
    );

    bct_channel #(.DW(DW)) i_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clk_off  (clk_off),
        .count    (count),
        .wr_ctl   (wr_cctl),
        .wr_hi    (wr_vh),
        .wr_lo    (wr_vl),
        .wdata    (bus_wdata),
        .cap_in   (cap_in),
        .chv      (chv),
        .flag     (flag),
        .cap_mode (cap_mode),
        .cmp_out  (cmp_out)
    );

    // Read mux; saved low bytes are used only outside debug halt.
    always_comb begin
        cctl_rd       = '0;
        cctl_rd[DW-1] = flag;
        cctl_rd[0]    = cap_mode;
        case (bus_addr)
            A_TCTL:  bus_rdata = DW'({clk_sel, psc_sel});
            A_CNTH:  bus_rdata = count[CW-1:DW];
            A_CNTL:  bus_rdata = (cnt_held && !dbg_halt) ? cnt_held_lo : count[DW-1:0];
            A_CCTL:  bus_rdata = cctl_rd;
            A_CHVH:  bus_rdata = chv[CW-1:DW];
            A_CHVL:  bus_rdata = (ch_held && !dbg_halt) ? ch_held_lo : chv[DW-1:0];
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/bct_timer_chk.sv
// Checker for bct_timer, attached by bind. Assumes a single bus strobe per
// cycle and cap_in held low during reset.
module bct_timer_chk
    import bct_pkg::*;
#(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   bus_addr,
    input logic            bus_wr,
    input logic [1:0]      clk_sel,
    input logic            dbg_halt,
    input logic            cap_in,
    input logic            cmp_out,
    input logic [2*DW-1:0] count,
    input logic [2*DW-1:0] chv,
    input logic            flag,
    input logic            cap_mode
);
    logic cnt_wr, chv_wr;
    assign cnt_wr = bus_wr && ((bus_addr == A_CNTH) || (bus_addr == A_CNTL));
    assign chv_wr = bus_wr && ((bus_addr == A_CHVH) || (bus_addr == A_CHVL));

    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(count) && !$past(cnt_wr)) |-> (count == 16'($past(count) + 1'b1))); // R2
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 2'b00 && !cnt_wr) |=> $stable(count)); // R3
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count == '0)); // R4
    AST_DBG_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt && !cnt_wr) |=> $stable(count)); // R6
    AST_CAP_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode && chv_wr && !cap_in) |=> $stable(chv)); // R8
    AST_TOGGLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmp_out) |-> flag); // R11
    AST_CAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode && cap_in && !$past(cap_in)) |=> (flag && chv == $past(count))); // R12
endmodule

bind bct_timer bct_timer_chk #(.DW(DW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .clk_sel  (clk_sel),
    .dbg_halt (dbg_halt),
    .cap_in   (cap_in),
    .cmp_out  (cmp_out),
    .count    (count),
    .chv      (chv),
    .flag     (flag),
    .cap_mode (cap_mode)
);

// File: tb/test_bct_timer.sv
// Bench for bct_timer: prescale sweeps, wrap, coherency and debug sequences.
module test_bct_timer;
    localparam int CLK_P = 10;
    localparam logic [2:0] TC = 3'd0, CH = 3'd1, CL = 3'd2, XC = 3'd3, VH = 3'd4, VL = 3'd5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [1:0] clk_sel = 2'b00;
    logic [2:0] psc_sel = 3'd5;
    logic       dbg_halt = 1'b0, cap_in = 1'b0, cmp_out;
    int         n_chk = 0, n_bad = 0;
    logic [7:0] d;
    logic [15:0] v;
    logic       o;

    always #(CLK_P/2) clk = ~clk;

    bct_timer i_bct_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_sel(clk_sel), .psc_sel(psc_sel),
        .dbg_halt(dbg_halt), .cap_in(cap_in), .cmp_out(cmp_out)
    );

    task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] x);
        bus_addr = a; bus_wdata = x; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] x);
        bus_addr = a; bus_rd = 1'b1;
        #(CLK_P/4);
        x = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd16(input logic [2:0] a, output logic [15:0] x);
        logic [7:0] h, l;
        rd(a, h);
        rd(a + 3'd1, l);
        x = {h, l};
    endtask

    task automatic run(input int m);
        clk_sel = 2'b01;
        repeat (m) @(negedge clk);
        clk_sel = 2'b00;
    endtask

    task automatic idle(input int m);
        repeat (m) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 180000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state and control readback (R3)
        rd16(CH, v); chk("R4 reset count", v, 16'h0000);
        rd(XC, d);   chk("R13 reset chctl", 16'(d), 16'h0000);
        chk("R11 reset cmp_out", 16'(cmp_out), 16'h0000);
        rd(TC, d);   chk("R3 ctl readback", 16'(d), 16'h0005);

        // R1: prescale sweep
        for (int n = 0; n < 8; n++) begin
            for (int k = 0; k < 2; k++) begin
                int m;
                m = (k == 0) ? 300 : 1000;
                psc_sel = 3'(n);
                wr(CL, 8'h00);
                run(m);
                rd16(CH, v);
                chk("R1 prescale", v, 16'(m >> n));
            end
        end

        // R3: stopped clock holds count and prescaler phase
        psc_sel = 3'd2; wr(CL, 8'h00); run(6); idle(50); run(2);
        rd16(CH, v); chk("R3 stop holds phase", v, 16'd2);

        // R4: counter write clears counter and prescaler
        psc_sel = 3'd3; wr(CL, 8'h00); run(5); wr(CH, 8'h00); run(3);
        rd16(CH, v); chk("R4 prescaler restart", v, 16'd0);
        run(5); rd16(CH, v); chk("R4 first tick", v, 16'd1);
        psc_sel = 3'd0; wr(CL, 8'h00); run(20);
        rd16(CH, v); chk("R1 short run", v, 16'd20);
        wr(CH, 8'h55); rd16(CH, v); chk("R4 clear", v, 16'd0);

        // R2: wrap
        wr(CL, 8'h00); run(65535);
        rd16(CH, v); chk("R2 top", v, 16'hFFFF);
        run(1); rd16(CH, v); chk("R2 wrap", v, 16'h0000);
        run(3); rd16(CH, v); chk("R2 after wrap", v, 16'h0003);

        // R5: counter coherency
        wr(CL, 8'h00); run(510);
        rd(CH, d); chk("R5 cnt hi", 16'(d), 16'h0001);
        run(5);
        rd(CL, d); chk("R5 cnt saved lo", 16'(d), 16'h00FE);
        rd(CL, d); chk("R5 cnt released lo", 16'(d), 16'h0003);

        // R10: immediate commit with clock off
        wr(XC, 8'h00);
        wr(VH, 8'h12); rd16(VH, v); chk("R10 lone byte", v, 16'h0000);
        wr(VL, 8'h34); rd16(VH, v); chk("R10 pair", v, 16'h1234);
        wr(VL, 8'h56); rd16(VH, v); chk("R10 lone lo", v, 16'h1234);
        wr(VH, 8'h78); rd16(VH, v); chk("R10 reversed pair", v, 16'h7856);

        // R5: channel coherency
        wr(VH, 8'h12); wr(VL, 8'h34);
        rd(VH, d); chk("R5 ch hi", 16'(d), 16'h0012);
        wr(VH, 8'h56); wr(VL, 8'h78);
        rd(VL, d); chk("R5 ch saved lo", 16'(d), 16'h0034);
        rd(VL, d); chk("R5 ch released lo", 16'(d), 16'h0078);

        // R9: buffered commit at next counter step
        psc_sel = 3'd7; clk_sel = 2'b01;
        wr(CL, 8'h00);
        wr(VH, 8'h00); wr(VL, 8'h05);
        rd16(VH, v); chk("R9 before step", v, 16'h5678);
        idle(130);
        rd16(VH, v); chk("R9 after step", v, 16'h0005);
        clk_sel = 2'b00;

        // R6: debug freezes counter, reads live, latch untouched
        psc_sel = 3'd0; wr(CL, 8'h00); run(40);
        rd(CH, d); run(7);
        dbg_halt = 1'b1; clk_sel = 2'b01; idle(10);
        rd(CL, d); chk("R6 frozen live lo", 16'(d), 16'h002F);
        rd(CH, d); chk("R6 frozen hi", 16'(d), 16'h0000);
        dbg_halt = 1'b0; clk_sel = 2'b00;
        rd(CL, d); chk("R6 latch kept", 16'(d), 16'h0028);
        rd(CL, d); chk("R6 released", 16'(d), 16'h002F);

        // R7: debug writes discard counter latch
        rd(CH, d); run(3);
        dbg_halt = 1'b1; wr(TC, 8'h00); dbg_halt = 1'b0;
        rd(CL, d); chk("R7 ctl write clears", 16'(d), 16'h0032);
        rd(CH, d); run(4);
        dbg_halt = 1'b1; wr(CH, 8'h00); dbg_halt = 1'b0;
        rd(CL, d); chk("R7 cnt write clears", 16'(d), 16'h0000);

        // R6/R7: channel value in debug
        rd(VH, d); wr(VH, 8'hAB); wr(VL, 8'hCD);
        dbg_halt = 1'b1; rd(VL, d); chk("R6 ch live", 16'(d), 16'h00CD);
        dbg_halt = 1'b0; rd(VL, d); chk("R6 ch latch kept", 16'(d), 16'h0005);
        rd(VH, d); wr(VH, 8'h11); wr(VL, 8'h22);
        dbg_halt = 1'b1; wr(XC, 8'h00); dbg_halt = 1'b0;
        rd(VL, d); chk("R7 chctl clears", 16'(d), 16'h0022);

        // R11: compare match
        wr(VH, 8'h00); wr(VL, 8'h32);
        wr(CL, 8'h00); wr(XC, 8'h80);
        o = cmp_out;
        run(49);
        rd(XC, d); chk("R11 no flag yet", 16'(d[7]), 16'h0000);
        chk("R11 out held", 16'(cmp_out), 16'(o));
        run(1);
        rd(XC, d); chk("R11 flag on match", 16'(d[7]), 16'h0001);
        chk("R11 out toggled", 16'(cmp_out), 16'(!o));

        // R12/R13: capture and flag clear
        wr(CL, 8'h00); run(123);
        wr(XC, 8'h81); rd(XC, d); chk("R13 clear", 16'(d), 16'h0001);
        cap_in = 1'b1; idle(1); cap_in = 1'b0;
        rd16(VH, v); chk("R12 captured", v, 16'd123);
        rd(XC, d); chk("R12 flag", 16'(d), 16'h0081);
        wr(XC, 8'h01); rd(XC, d); chk("R13 write zero keeps", 16'(d), 16'h0081);
        wr(XC, 8'h81); rd(XC, d); chk("R13 write one clears", 16'(d), 16'h0001);
        cap_in = 1'b1; idle(1); run(10);
        rd16(VH, v); chk("R12 level no recapture", v, 16'd123);
        cap_in = 1'b0;

        // R8: capture mode ignores value writes
        wr(VH, 8'hAA); wr(VL, 8'hBB);
        rd16(VH, v); chk("R8 ignore clk off", v, 16'd123);
        clk_sel = 2'b01; wr(VH, 8'h01); wr(VL, 8'h02); clk_sel = 2'b00;
        idle(3);
        rd16(VH, v); chk("R8 ignore clk on", v, 16'd123);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule